// File: doc/BRIEF.md
# Receiver Inactivity Timeout Counter

This block is a 16-bit down counter that can serve two purposes. In normal mode, software runs it with start and stop commands. After each expiry it reloads and keeps running, and it raises a ready flag that feeds an interrupt status bit. In timeout mode, the receivers drive it. Each time a character moves from a receiver's shift register into its receive FIFO, the count restarts from the preload value. The ready flag therefore rises only after the line has been idle for a full period.

Each of the two receivers has its own timeout-mode enable. The block is in timeout mode while either enable is set. A restart comes from any receiver whose enable is set, so when both are on, expiry needs both lines to be quiet. While timeout mode is active, the start and stop commands are locked out. Clearing the enables returns control to those commands but does not stop the counter.

All outputs are registered. A command, strobe or tick that is sampled on a clock edge shows on the outputs right after that edge.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, `ready` is 0, `count` is 0, `to_mode` is 0 and the counter is stopped.
- R2: In normal mode, `cmd_start` loads `preload` into `count` and starts the counter. A running counter decrements by one on each cycle with `tick` high and holds its value on cycles without `tick`.
- R3: A running counter that sees `tick` while `count` is 0 sets `ready`. With preload N, `ready` therefore rises on the N+1th tick. In normal mode the counter then reloads `preload` and keeps running.
- R4: In normal mode, `cmd_stop` halts the counter and clears `ready`. When it arrives in the same cycle as `cmd_start`, stop wins and nothing is loaded.
- R5: A `cmd_to_on` pulse on bit i sets `to_mode[i]`, stops the counter and clears `ready`.
- R6: While `to_mode` is non-zero, `cmd_start` and `cmd_stop` have no effect on `count` or `ready`.
- R7: In timeout mode, an `rx_xfer[i]` pulse with `to_mode[i]` set reloads `preload`, starts the counter and clears `ready`. A pulse on a receiver whose mode bit is clear is ignored.
- R8: With both mode bits set, a transfer on either receiver restarts the count. Expiry requires a full period with no transfer from either receiver.
- R9: In timeout mode, expiry sets `ready` and halts the counter at 0 until the next restart.
- R10: A `cmd_to_off` pulse on bit i clears `to_mode[i]` but neither stops the counter nor clears `ready`. Once `to_mode` is 0, start and stop work again.
- R11: A preload of 0 expires on the first tick after a start or restart.
- R12: In the same cycle, `cmd_to_on` takes priority over a transfer strobe (the counter is stopped, not reloaded). A mode bit that gets on and off together ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| preload | input | 16 | Value loaded on start or restart |
| cmd_start | input | 1 | Start command pulse (normal mode only) |
| cmd_stop | input | 1 | Stop command pulse, also clears ready (normal mode only) |
| cmd_to_on | input | 2 | Per-receiver timeout-mode enable pulses |
| cmd_to_off | input | 2 | Per-receiver timeout-mode disable pulses |
| rx_xfer | input | 2 | Per-receiver character-to-FIFO transfer strobes |
| ready | output | 1 | Counter-ready flag |
| count | output | 16 | Current counter value |
| to_mode | output | 2 | Per-receiver timeout-mode enables |

## Verification
The hardest case to reach is a mode handover while the counter is live. One example is a timeout period that is still counting when the last enable is removed: the count must carry on under normal-mode rules and reload at expiry instead of halting. Another is a ready flag raised in timeout mode that must survive the disable command. Directed sequences build these states step by step, and also cover the two-receiver overlap and the same-cycle collisions of on/off/transfer. A long seeded random run then mixes sparse commands and strobes against a cycle-level reference model.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;
  // Per-cycle instruction from the mode controller to the counter.
  typedef struct packed {
    logic stop;     // halt the counter
    logic load;     // load preload and run
    logic clr_rdy;  // clear ready flag
    logic halt_tc;  // stop at terminal count instead of reloading
  } ctr_cmd_t;
endpackage

// File: rtl/rx_idle_mode.sv
module rx_idle_mode
  import rx_idle_pkg::*;
#(
  parameter int NRX = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_start,
  input  logic           cmd_stop,
  input  logic [NRX-1:0] cmd_to_on,
  input  logic [NRX-1:0] cmd_to_off,
  input  logic [NRX-1:0] rx_xfer,
  output logic [NRX-1:0] to_en_q,
  output ctr_cmd_t       cmd
);
  logic [NRX-1:0] hit;
  logic           tmode, any_on, restart, sw_stop;

  // Per-receiver enable registers: on wins over off.
  for (genvar i = 0; i < NRX; i++) begin : g_rx
    always_ff @(posedge clk) begin
      if (rst)                to_en_q[i] <= 1'b0;
      else if (cmd_to_on[i])  to_en_q[i] <= 1'b1;
      else if (cmd_to_off[i]) to_en_q[i] <= 1'b0;
    end
    assign hit[i] = to_en_q[i] & rx_xfer[i];
  end

  always_comb begin
    tmode       = |to_en_q;
    any_on      = |cmd_to_on;
    restart     = tmode & (|hit) & ~any_on;
    sw_stop     = ~tmode & cmd_stop;
    cmd.stop    = any_on | sw_stop;
    cmd.clr_rdy = any_on | sw_stop | restart;
    cmd.load    = ~cmd.stop & (restart | (~tmode & cmd_start));
    cmd.halt_tc = tmode;
  end

  AST_ON_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
    (|cmd_to_on) |=> ((to_en_q & $past(cmd_to_on)) == $past(cmd_to_on))); // R12
endmodule

// File: rtl/rx_idle_counter.sv
module rx_idle_counter
  import rx_idle_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] preload,
  input  ctr_cmd_t     cmd,
  output logic [W-1:0] cnt_q,
  output logic         rdy_q
);
  logic run_q;
  logic step, at_tc;

  assign step  = run_q & tick & ~cmd.stop & ~cmd.load;
  assign at_tc = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cmd.stop) begin
      run_q <= 1'b0;
    end else if (cmd.load) begin
      cnt_q <= preload;
      run_q <= 1'b1;
    end else if (step) begin
      if (at_tc) begin
        if (cmd.halt_tc) run_q <= 1'b0;
        else             cnt_q <= preload;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rdy_q <= 1'b0;
    else if (cmd.clr_rdy)   rdy_q <= 1'b0;
    else if (step && at_tc) rdy_q <= 1'b1;
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cmd.stop && !cmd.load) |=> $stable(cnt_q)); // R2
  AST_READY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> ($past(cnt_q) == '0 && $past(tick))); // R3
  AST_CLEAR_READY: assert property (@(posedge clk) disable iff (rst)
    cmd.clr_rdy |=> !rdy_q); // R4
  AST_LOAD_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> (cnt_q == $past(preload) && run_q)); // R7
  AST_TIMEOUT_HALT: assert property (@(posedge clk) disable iff (rst)
    (step && at_tc && cmd.halt_tc) |=> (!run_q && rdy_q)); // R9
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rx_idle_pkg::*;
#(
  parameter int W   = 16,
  parameter int NRX = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [W-1:0]   preload,
  input  logic           cmd_start,
  input  logic           cmd_stop,
  input  logic [NRX-1:0] cmd_to_on,
  input  logic [NRX-1:0] cmd_to_off,
  input  logic [NRX-1:0] rx_xfer,
  output logic           ready,
  output logic [W-1:0]   count,
  output logic [NRX-1:0] to_mode
);
  ctr_cmd_t ccmd;

  rx_idle_mode #(.NRX(NRX)) mode_i (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_to_on(cmd_to_on), .cmd_to_off(cmd_to_off), .rx_xfer(rx_xfer),
    .to_en_q(to_mode), .cmd(ccmd)
  );

  rx_idle_counter #(.W(W)) ctr_i (
    .clk(clk), .rst(rst), .tick(tick), .preload(preload), .cmd(ccmd),
    .cnt_q(count), .rdy_q(ready)
  );

  AST_TO_ON_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|cmd_to_on) |=> !ready); // R5
endmodule

// File: tb/rx_idle_timer_tb.sv
module rx_idle_timer_tb_top;
  logic        clk = 0, rst = 1, tick = 0;
  logic [15:0] preload = 0;
  logic        cmd_start = 0, cmd_stop = 0;
  logic [1:0]  cmd_to_on = 0, cmd_to_off = 0, rx_xfer = 0;
  logic        ready;
  logic [15:0] count;
  logic [1:0]  to_mode;

  int checks = 0, errors = 0;
  // reference model state
  logic [1:0]  m_en = 0;
  logic        m_run = 0, m_rdy = 0;
  logic [15:0] m_cnt = 0;

  always #5 clk = ~clk;

  rx_idle_timer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .preload(preload),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_to_on(cmd_to_on),
    .cmd_to_off(cmd_to_off), .rx_xfer(rx_xfer),
    .ready(ready), .count(count), .to_mode(to_mode)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Next state per the requirements.
  task automatic model_step();
    logic tm, on, rs, st, ld, stp;
    tm  = |m_en;
    on  = |cmd_to_on;
    rs  = tm && |(m_en & rx_xfer) && !on;            // R7 R8 R12
    st  = on || (!tm && cmd_stop);                   // R4 R5 R6
    ld  = !st && (rs || (!tm && cmd_start));         // R2 R6
    stp = m_run && tick && !st && !ld;
    if (st || rs)              m_rdy = 0;
    else if (stp && m_cnt == 0) m_rdy = 1;           // R3
    if (st) m_run = 0;
    else if (ld) begin m_cnt = preload; m_run = 1; end
    else if (stp) begin
      if (m_cnt == 0) begin
        if (tm) m_run = 0;                           // R9
        else    m_cnt = preload;
      end else m_cnt = m_cnt - 1;
    end
    m_en = (m_en & ~cmd_to_off) | cmd_to_on;         // R10 R12
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    chk("R2 count model", count, m_cnt);
    chk("R3 ready model", ready, m_rdy);
    chk("R5 to_mode model", to_mode, m_en);
    cmd_start = 0; cmd_stop = 0; cmd_to_on = 0; cmd_to_off = 0; rx_xfer = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R1 ready", ready, 0); chk("R1 count", count, 0); chk("R1 to_mode", to_mode, 0);
    tick = 1; cyc(); chk("R1 stopped", count, 0);
    tick = 0;
    // normal mode
    preload = 3; cmd_start = 1; cyc(); chk("R2 load", count, 3);
    cyc(); chk("R2 hold", count, 3);
    tick = 1; repeat (3) cyc(); chk("R3 at zero", count, 0); chk("R3 not yet", ready, 0);
    cyc(); chk("R3 ready", ready, 1); chk("R3 reload", count, 3);
    cyc(); chk("R3 running", count, 2);
    cmd_start = 1; cmd_stop = 1; cyc(); chk("R4 clr", ready, 0); chk("R4 stop wins", count, 2);
    cyc(); chk("R4 halted", count, 2);
    // timeout on
    cmd_start = 1; cyc(); cyc(); chk("R2 run", count, 2);
    cmd_to_on = 2'b01; cyc(); chk("R5 mode", to_mode, 1); chk("R5 stop", count, 2);
    cyc(); chk("R5 stopped", count, 2);
    cmd_start = 1; cyc(); chk("R6 start locked", count, 2);
    rx_xfer = 2'b10; cyc(); cyc(); chk("R7 ignored", count, 2);
    preload = 2; rx_xfer = 2'b01; cyc(); chk("R7 restart", count, 2);
    cyc(); cyc(); chk("R9 zero", count, 0); chk("R9 pending", ready, 0);
    cyc(); chk("R9 ready", ready, 1);
    repeat (3) cyc(); chk("R9 halt", count, 0);
    cmd_stop = 1; cyc(); chk("R6 stop locked", ready, 1);
    cmd_to_on = 2'b10; cyc(); chk("R5 both", to_mode, 3); chk("R5 clr", ready, 0);
    // two receivers
    rx_xfer = 2'b01; cyc(); cyc(); chk("R8 count", count, 1);
    rx_xfer = 2'b10; cyc(); chk("R8 restart rx1", count, 2);
    cyc(); cyc(); chk("R8 quiet", ready, 0);
    cyc(); chk("R8 expire", ready, 1);
    // collisions
    preload = 5; cmd_to_on = 2'b01; rx_xfer = 2'b01; cyc();
    chk("R12 no reload", count, 0); chk("R12 clr", ready, 0);
    cmd_to_on = 2'b10; cmd_to_off = 2'b10; cyc(); chk("R12 on wins", to_mode, 3);
    // zero preload and handover
    preload = 0; rx_xfer = 2'b01; cyc(); cyc(); chk("R11 first tick", ready, 1);
    cmd_to_off = 2'b01; cyc(); chk("R10 keep ready", ready, 1); chk("R10 mode", to_mode, 2);
    preload = 5; rx_xfer = 2'b10; cyc(); cyc(); chk("R7 rx1", count, 4);
    cmd_to_off = 2'b10; cyc(); chk("R10 off", to_mode, 0); chk("R10 runs", count, 3);
    cyc(); chk("R10 still", count, 2);
    cmd_stop = 1; cyc(); chk("R10 stop", count, 2);
    cyc(); chk("R10 stopped", count, 2);
    preload = 0; cmd_start = 1; cyc(); cyc(); chk("R11 normal", ready, 1);
    // random phase
    void'($urandom(32'h5eed1234));
    for (int n = 0; n < 6000; n++) begin
      tick       = ($urandom % 2) == 0;
      cmd_start  = ($urandom % 32) == 0;
      cmd_stop   = ($urandom % 32) == 0;
      cmd_to_on  = {($urandom % 60) == 0, ($urandom % 60) == 0};
      cmd_to_off = {($urandom % 60) == 0, ($urandom % 60) == 0};
      rx_xfer    = {($urandom % 25) == 0, ($urandom % 25) == 0};
      if (($urandom % 50) == 0) preload = 16'($urandom % 12);
      cyc();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule